// File: doc/BRIEF.md
# Transmit DMA Burst Request Generator

This block sits between a fixed-size transmit byte buffer and a system DMA engine inside a serial frame controller. When software starts a frame of a given length, the block cuts the frame into bursts of `BLOCK` bytes, with a shorter final burst when the length is not a whole number of bursts. For each burst it raises a DMA request and holds it until that many bytes have been accepted. One byte is accepted on every clock in which the request and the DMA acknowledge are both high. It issues the next request only when the buffer has room for the whole next burst, because a serializer drains the buffer one byte per pop strobe.

Once every byte has been written and the buffer has drained to empty, the block gives a one-cycle interrupt pulse and sets a sticky "transmit pool ready" status bit. Software polls this bit, and a status read clears it. The buffer depth must be at least `BLOCK`.

The controller has four named states. `ST_IDLE` goes to `ST_WAIT_ROOM` on an accepted start. `ST_WAIT_ROOM` goes to `ST_BURST` once there is room for the next burst. `ST_BURST` goes back to `ST_WAIT_ROOM` at the end of a burst that is not the last one, or to `ST_DRAIN` after the last byte of the frame. `ST_DRAIN` goes to `ST_IDLE` when the buffer is empty, and that transition raises the interrupt and sets the status bit.

Top module: `txdma_reqgen`

## Requirements
- R1: While reset is low, and in the first cycle after it, `dma_req`, `fifo_wr`, `tx_irq` and `tx_ready` are all 0.
- R2: A frame of N bytes (1 ≤ N ≤ MAX_LEN) produces ceil(N/BLOCK) request pulses. Every burst except the last carries BLOCK bytes. The last carries N − (pulses−1)·BLOCK bytes, which is a full BLOCK when N is a multiple of BLOCK.
- R3: Once raised, `dma_req` stays high until its burst's byte count has been accepted. `fifo_wr` is high exactly in the cycles where `dma_req` and `dma_ack` are both high, and each such cycle moves one byte.
- R4: `dma_ack` while `dma_req` is low is ignored: no `fifo_wr` and no progress through the frame.
- R5: The buffer level is the bytes written minus the effective pops. A request rises only when DEPTH − level is at least the size of the burst it will carry, and the level never exceeds DEPTH.
- R6: After the last byte has been written and the buffer is empty, `tx_irq` pulses high for exactly one cycle, and `tx_ready` is 1 in that same cycle.
- R7: `tx_ready` stays set until a cycle with `status_rd` high, after which it reads 0. If completion and a read fall in the same cycle, the set wins.
- R8: `start` is ignored while a frame is in progress. A start with `frame_len` of 0, or with `frame_len` greater than MAX_LEN, is ignored.
- R9: `fifo_pop` while the buffer is empty has no effect on the level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle frame start strobe |
| frame_len | input | $clog2(MAX_LEN+1) | Frame length in bytes, sampled with `start` |
| dma_ack | input | 1 | DMA acknowledge; a byte transfers when it is high together with `dma_req` |
| fifo_pop | input | 1 | Serializer removes one byte from the buffer |
| status_rd | input | 1 | CPU read of the ready status; clears it |
| dma_req | output | 1 | DMA burst request |
| fifo_wr | output | 1 | Byte written into the buffer this cycle |
| tx_irq | output | 1 | One-cycle end-of-frame interrupt pulse |
| tx_ready | output | 1 | Sticky transmit-pool-ready status bit |

## Verification
The bench builds the block with BLOCK=8, DEPTH=8 and MAX_LEN=64. With these values a maximum-length frame needs eight bursts, and an exact-multiple frame, a single-byte frame and an over-limit length of 65 can all be reached in a few hundred cycles. Because the depth equals the burst size, stopping the serializer after one burst leaves the buffer full. That makes the wait for room directly observable. It also exposes any wrong level caused by pops issued while the buffer is empty.

// File: rtl/txdma_pkg.sv
package txdma_pkg;
    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_WAIT_ROOM = 2'd1,
        ST_BURST     = 2'd2,
        ST_DRAIN     = 2'd3
    } txdma_state_e;
endpackage

// File: rtl/txdma_level.sv
module txdma_level #(
    parameter int DEPTH = 32,
    localparam int LVW = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr,
    input  logic           pop,
    output logic [LVW-1:0] level,
    output logic           empty
);
    logic pop_eff;

    assign empty   = (level == '0);
    assign pop_eff = pop && !empty;   // R9: pop on empty buffer ignored

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= '0;
        end else if (wr && !pop_eff) begin
            level <= level + 1'b1;
        end else if (pop_eff && !wr) begin
            level <= level - 1'b1;
        end
    end

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        32'(level) <= DEPTH);

    assert_empty_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !wr) |=> (level == '0));
endmodule

// File: rtl/txdma_seg.sv
module txdma_seg #(
    parameter int BLOCK   = 32,
    parameter int MAX_LEN = 4096,
    localparam int LW = $clog2(MAX_LEN + 1),
    localparam int BW = $clog2(BLOCK + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [LW-1:0] len,
    input  logic          take,
    input  logic          blk_load,
    output logic [LW-1:0] rem,
    output logic [BW-1:0] chunk,
    output logic          blk_last,
    output logic          frame_last
);
    logic [BW-1:0] blk_left;

    always_comb begin
        if (32'(rem) < BLOCK) begin
            chunk = BW'(rem);
        end else begin
            chunk = BW'(BLOCK);
        end
    end

    assign blk_last   = (blk_left == BW'(1));
    assign frame_last = (rem == LW'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem      <= '0;
            blk_left <= '0;
        end else begin
            if (load) begin
                rem <= len;
            end else if (take) begin
                rem <= rem - 1'b1;
            end
            if (blk_load) begin
                blk_left <= chunk;
            end else if (take) begin
                blk_left <= blk_left - 1'b1;
            end
        end
    end

    assert_rem_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (rem != '0 && blk_left != '0));
endmodule

// File: rtl/txdma_reqgen.sv
module txdma_reqgen
    import txdma_pkg::*;
#(
    parameter int BLOCK   = 32,
    parameter int DEPTH   = 32,
    parameter int MAX_LEN = 4096,
    localparam int LW  = $clog2(MAX_LEN + 1),
    localparam int BW  = $clog2(BLOCK + 1),
    localparam int LVW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [LW-1:0] frame_len,
    input  logic          dma_ack,
    input  logic          fifo_pop,
    input  logic          status_rd,
    output logic          dma_req,
    output logic          fifo_wr,
    output logic          tx_irq,
    output logic          tx_ready
);
    txdma_state_e state, state_nx;

    logic [LVW-1:0] level;
    logic           empty;
    logic [LW-1:0]  rem;
    logic [BW-1:0]  chunk;
    logic           blk_last, frame_last;
    logic           len_ok, start_ok, room_ok, blk_load, done;

    assign len_ok   = (frame_len != '0) && (32'(frame_len) <= MAX_LEN);
    assign start_ok = start && len_ok && (state == ST_IDLE);
    assign room_ok  = (DEPTH - 32'(level)) >= 32'(chunk);
    assign blk_load = (state == ST_WAIT_ROOM) && room_ok;
    assign done     = (state == ST_DRAIN) && empty;

    txdma_level #(.DEPTH(DEPTH)) u_level (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (fifo_wr),
        .pop   (fifo_pop),
        .level (level),
        .empty (empty)
    );

    txdma_seg #(.BLOCK(BLOCK), .MAX_LEN(MAX_LEN)) u_seg (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (start_ok),
        .len        (frame_len),
        .take       (fifo_wr),
        .blk_load   (blk_load),
        .rem        (rem),
        .chunk      (chunk),
        .blk_last   (blk_last),
        .frame_last (frame_last)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:      if (start_ok) state_nx = ST_WAIT_ROOM;
            ST_WAIT_ROOM: if (room_ok)  state_nx = ST_BURST;
            ST_BURST: begin
                if (fifo_wr && blk_last) begin
                    state_nx = frame_last ? ST_DRAIN : ST_WAIT_ROOM;
                end
            end
            ST_DRAIN:     if (empty)    state_nx = ST_IDLE;
            default:                    state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    assign dma_req = (state == ST_BURST);
    assign fifo_wr = dma_req && dma_ack;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_irq   <= 1'b0;
            tx_ready <= 1'b0;
        end else begin
            tx_irq <= done;
            if (done) begin
                tx_ready <= 1'b1;
            end else if (status_rd) begin
                tx_ready <= 1'b0;
            end
        end
    end

    assert_req_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && !(dma_ack && blk_last)) |=> dma_req);

    assert_ack_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!dma_req && !start_ok) |=> $stable(rem));

    assert_room_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_req) |-> ((DEPTH - 32'(level)) >= 32'(chunk)));

    assert_irq_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |-> (tx_ready && empty && !dma_req));

    assert_irq_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |=> !tx_irq);

    assert_ready_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd && !done) |=> !tx_ready);

    assert_busy_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && state != ST_IDLE) |=> (state != ST_IDLE || $past(state) == ST_DRAIN));
endmodule

// File: tb/txdma_reqgen_tb.sv
module txdma_reqgen_tb;
    localparam int CLK_PERIOD = 10;
    localparam int B   = 8;
    localparam int D   = 8;
    localparam int MX  = 64;
    localparam int LW  = $clog2(MX + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [LW-1:0] frame_len = '0;
    logic dma_ack = 1'b0;
    logic fifo_pop = 1'b0;
    logic status_rd = 1'b0;
    logic dma_req, fifo_wr, tx_irq, tx_ready;

    int total = 0;
    int bad = 0;
    int ack_mode = 3;
    int pop_mode = 0;
    int cyc = 0;

    int pulses, cur, written, mlevel, irqs, cur_n;
    int sizes [0:15];
    logic prev_req = 1'b0;

    txdma_reqgen #(.BLOCK(B), .DEPTH(D), .MAX_LEN(MX)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .frame_len(frame_len),
        .dma_ack(dma_ack), .fifo_pop(fifo_pop), .status_rd(status_rd),
        .dma_req(dma_req), .fifo_wr(fifo_wr), .tx_irq(tx_irq), .tx_ready(tx_ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // stimulus patterns driven just after each rising edge
    always @(posedge clk) begin
        #1;
        cyc++;
        case (ack_mode)
            0: dma_ack = 1'b1;
            1: dma_ack = cyc[0];
            2: dma_ack = (cyc % 3 == 0);
            default: dma_ack = 1'b0;
        endcase
        case (pop_mode)
            1: fifo_pop = 1'b1;
            2: fifo_pop = (cyc % 3 == 0);
            default: fifo_pop = 1'b0;
        endcase
    end

    // monitor on the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (fifo_wr !== (dma_req && dma_ack))
                chk(0, "R4 fifo_wr vs req&ack", fifo_wr, dma_req && dma_ack);
            if (dma_req && !prev_req) begin
                int want;
                want = (cur_n - written < B) ? cur_n - written : B;
                if (D - mlevel < want) chk(0, "R5 room at request", D - mlevel, want);
                cur = 0;
                pulses++;
            end
            if (!dma_req && prev_req && pulses > 0 && pulses <= 16) sizes[pulses-1] = cur;
            if (tx_irq) begin
                irqs++;
                if (tx_ready !== 1'b1) chk(0, "R6 ready with irq", tx_ready, 1);
                if (mlevel != 0) chk(0, "R6 buffer empty at irq", mlevel, 0);
                if (written != cur_n) chk(0, "R6 all bytes written at irq", written, cur_n);
            end
            if (fifo_pop && mlevel > 0) mlevel--;
            if (fifo_wr) begin
                cur++;
                written++;
                mlevel++;
            end
            if (mlevel > D) chk(0, "R5 level above depth", mlevel, D);
            prev_req = dma_req;
        end
    end

    task automatic clr_model(input int n);
        pulses = 0; cur = 0; written = 0; irqs = 0; cur_n = n;
        for (int i = 0; i < 16; i++) sizes[i] = 0;
    endtask

    task automatic wait_irq();
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (irqs != 0) break;
        end
    endtask

    task automatic pulse_start(input int n);
        @(posedge clk); #2;
        frame_len = LW'(n);
        start = 1'b1;
        @(posedge clk); #2;
        start = 1'b0;
    endtask

    task automatic check_bursts(input int n, input string tag);
        int np;
        np = (n + B - 1) / B;
        chk(pulses == np, {tag, " R2 pulse count"}, pulses, np);
        for (int i = 0; i < np; i++) begin
            int e;
            e = (i < np - 1) ? B : n - (np - 1) * B;
            chk(sizes[i] == e, {tag, " R2/R3 burst size"}, sizes[i], e);
        end
        chk(written == n, {tag, " R3 bytes moved"}, written, n);
        chk(irqs == 1, {tag, " R6 one irq pulse"}, irqs, 1);
    endtask

    task automatic read_clear(input string tag);
        @(posedge clk); #2; status_rd = 1'b1;
        @(posedge clk); #2; status_rd = 1'b0;
        @(negedge clk);
        chk(tx_ready == 1'b0, {tag, " R7 read clears ready"}, tx_ready, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk({dma_req, fifo_wr, tx_irq, tx_ready} == 4'b0, "R1 outputs in reset",
            {dma_req, fifo_wr, tx_irq, tx_ready}, 0);
        @(posedge clk); #2; rst_n = 1'b1;
        @(negedge clk);
        chk({dma_req, fifo_wr, tx_irq, tx_ready} == 4'b0, "R1 outputs after reset",
            {dma_req, fifo_wr, tx_irq, tx_ready}, 0);
        mlevel = 0;
    endtask

    task automatic t_frame(input int n, input int am, input int pm, input string tag);
        clr_model(n);
        ack_mode = am; pop_mode = pm;
        pulse_start(n);
        wait_irq();
        check_bursts(n, tag);
        @(negedge clk);
        chk(tx_ready == 1'b1, {tag, " R6/R7 ready held"}, tx_ready, 1);
        read_clear(tag);
    endtask

    task automatic t_max_read_held();
        clr_model(MX);
        ack_mode = 1; pop_mode = 2;
        @(posedge clk); #2; status_rd = 1'b1;
        pulse_start(MX);
        wait_irq();
        check_bursts(MX, "max");
        @(posedge clk); #2; status_rd = 1'b0;
        @(negedge clk);
        chk(tx_ready == 1'b0, "R7 set wins then read clears", tx_ready, 0);
    endtask

    task automatic t_ack_idle();
        clr_model(3);
        ack_mode = 0; pop_mode = 1;
        repeat (10) @(negedge clk);
        chk(written == 0 && dma_req == 1'b0, "R4 ack while idle ignored", written, 0);
        pulse_start(3);
        wait_irq();
        check_bursts(3, "after idle ack");
        read_clear("after idle ack");
    endtask

    task automatic t_busy_start();
        clr_model(10);
        ack_mode = 1; pop_mode = 1;
        pulse_start(10);
        repeat (2) @(posedge clk);
        #2; frame_len = LW'(20); start = 1'b1;
        @(posedge clk); #2; start = 1'b0;
        wait_irq();
        check_bursts(10, "busy start");
        repeat (20) @(negedge clk);
        chk(written == 10 && pulses == 2, "R8 second start ignored", written, 10);
        read_clear("busy start");
    endtask

    task automatic t_bad_len(input int n, input string tag);
        clr_model(n);
        ack_mode = 0; pop_mode = 1;
        pulse_start(n);
        repeat (20) @(negedge clk);
        chk(pulses == 0 && written == 0, {tag, " R8 bad length ignored"}, pulses, 0);
        chk(tx_ready == 1'b0 && irqs == 0, {tag, " R8 no completion"}, tx_ready, 0);
    endtask

    task automatic t_room_wait();
        ack_mode = 3; pop_mode = 1;
        repeat (10) @(negedge clk);   // pops on empty buffer
        clr_model(12);
        pop_mode = 0; ack_mode = 0;
        pulse_start(12);
        repeat (40) @(negedge clk);
        chk(written == 8, "R9 empty pops ignored, first burst taken", written, 8);
        chk(pulses == 1 && dma_req == 1'b0, "R5 no request without room", pulses, 1);
        pop_mode = 1;
        wait_irq();
        check_bursts(12, "room wait");
        read_clear("room wait");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        clr_model(0);
        mlevel = 0;
        t_reset();
        t_frame(20, 0, 1, "n20");
        t_frame(16, 0, 1, "n16 multiple");
        t_frame(1, 2, 1, "n1");
        t_frame(13, 2, 2, "n13 slow");
        t_max_read_held();
        t_ack_idle();
        t_busy_start();
        t_bad_len(0, "len0");
        t_bad_len(MX + 1, "len65");
        t_room_wait();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule